// File: doc/BRIEF.md
# Sticky Fault Status and Capture Register

This block records asynchronous error events raised by a processor's memory subsystem. Each error source delivers a one-cycle pulse that carries a flag index, an address, a 9-bit data-ECC syndrome, a 4-bit memory-tag syndrome, a transaction tag, a 16-byte sub-beat index and the current privilege level. Every flag is sticky. It stays set until software writes a 1 to its bit through a plain 64-bit synchronous write port. Reading through the status output never changes anything.

The block keeps one address capture and two syndrome captures, and each of them follows its own lock. A capture locks onto the highest-priority event it has seen. Only a strictly higher-priority event may replace it. The lock is released as soon as software clears the one flag that owns it, even if other flags are still set. The block also keeps a multiple-error flag, a sampled privilege bit and a filter for ECC events inside a single 64-byte transaction. A disrupting-trap request stays up while interrupts are enabled and any flag in the trap class is set.

Top module: `fault_status_log`

## Requirements
- R1: Flag i sits at status bit FLAG_LO+i (default FLAG_LO=33). An accepted event with index i sets it. Writing 1 to that bit clears it. Writing 0 leaves it unchanged.
- R2: The status output has no read side effects. The data-ECC syndrome at bits [8:0] and the memory-tag syndrome at bits [19:16] are unaffected by writes. All other bits outside the flag range, ME and PRIV read as 0.
- R3: The multiple-error bit ME (bit 53) is set when an accepted event of the uncorrectable or software-correctable class hits a flag that is already set and is not being cleared in that cycle. A repeat of a hardware-corrected flag does not set ME. Writing 1 to bit 53 clears ME.
- R4: Flags in ECC_MASK are ECC events. Once an ECC event of transaction tag T has been accepted, later ECC events with tag T and a non-zero beat index are dropped. A dropped event changes no flag, ME, PRIV or capture. An ECC event with beat 0 always starts a new transaction. Events outside ECC_MASK are never filtered.
- R5: PRIV (bit 52) takes the value of ev_priv on every accepted event. Writing 1 to bit 52 clears it, except when an event is accepted in the same cycle, in which case the event's value wins.
- R6: Each flag has a rank {class, index}, with class code 2 = uncorrectable, 1 = software-correctable (SWC_MASK) and 0 = hardware-corrected (HWC_MASK). A larger rank has higher priority. cap_addr captures an accepted event in ADDR_MASK when the capture is unlocked, or when the event's rank is strictly above the rank of the lock owner.
- R7: Writing 1 to the owner flag of a lock releases that lock, even if other flags remain set. The captured value is kept until the next capture.
- R8: The data-ECC syndrome (ESYN_MASK) and the memory-tag syndrome (MSYN_MASK) follow the R6 and R7 rules, each with its own lock.
- R9: trap_req equals irq_en AND (any set flag in TRAP_MASK).
- R10: When a write clears a flag and a new event for the same flag is accepted in the same cycle, the flag stays set. The locks are evaluated after the clear, so a released lock can be taken again in that same cycle.
- R11: After reset, all flags, ME, PRIV, the syndromes, cap_addr, the locks and the transaction filter are zero, and the filter is empty.
- R12: An event whose index is NF or greater is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Write strobe (write-1-to-clear) |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Status register contents |
| ev_vld | input | 1 | Error event pulse |
| ev_idx | input | $clog2(NF) | Flag index of the event |
| ev_addr | input | ADDR_W | Faulting address |
| ev_esyn | input | 9 | Data-ECC syndrome |
| ev_msyn | input | 4 | Memory-tag syndrome |
| ev_txn | input | TXN_W | Transaction tag |
| ev_beat | input | BEAT_W | 16-byte sub-beat index in the transaction |
| ev_priv | input | 1 | Privileged mode at detection |
| irq_en | input | 1 | Interrupt enable |
| trap_req | output | 1 | Disrupting-trap request |
| cap_addr | output | ADDR_W | Captured address |

## Verification
The bench builds the block with NF=6, ADDR_W=16, TXN_W=3 and BEAT_W=2. Two flags are hardware-corrected, one is software-correctable and three are uncorrectable. Four flags are ECC events, three can raise a trap, and the two syndrome masks overlap on a single flag. With this size the bench can sweep every ordered pair of flags, then release the first lock and inject a third flag. That walks each capture through every overwrite, hold and unlock case and every ME case. The 3-bit index also leaves two out-of-range codes to send.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;
  localparam int REG_W    = 64;
  localparam int POS_ME   = 53;
  localparam int POS_PRIV = 52;
  localparam int POS_MSYN = 16;
  localparam int POS_ESYN = 0;
  localparam int ESYN_W   = 9;
  localparam int MSYN_W   = 4;

  typedef enum logic [1:0] {
    CLS_HWC = 2'd0,
    CLS_SWC = 2'd1,
    CLS_UNC = 2'd2
  } cls_e;

  // Hardware-corrected membership wins if a flag is listed in both masks.
  function automatic cls_e class_of(logic hw, logic sw);
    if (hw) return CLS_HWC;
    if (sw) return CLS_SWC;
    return CLS_UNC;
  endfunction

  // Only these classes count a repeat as a multiple error.
  function automatic logic repeat_counts(cls_e c);
    return (c != CLS_HWC);
  endfunction
endpackage

// File: rtl/fsr_classify.sv
`timescale 1ns/1ps
module fsr_classify import fsr_pkg::*; #(
  parameter int NF = 19,
  parameter int IDX_W = 5,
  parameter logic [NF-1:0] HWC_MASK = '0,
  parameter logic [NF-1:0] SWC_MASK = '0,
  parameter logic [NF-1:0] ECC_MASK = '0
) (
  input  logic [IDX_W-1:0] idx,
  output logic             in_rng,
  output cls_e             cls,
  output logic             is_ecc
);
  localparam int SZ = 1 << IDX_W;
  localparam logic [SZ-1:0] HW_PAD  = SZ'(HWC_MASK);
  localparam logic [SZ-1:0] SW_PAD  = SZ'(SWC_MASK);
  localparam logic [SZ-1:0] ECC_PAD = SZ'(ECC_MASK);

  assign in_rng = (int'(idx) < NF);
  assign cls    = class_of(HW_PAD[idx], SW_PAD[idx]);
  assign is_ecc = in_rng & ECC_PAD[idx];
endmodule

// File: rtl/fsr_beat_filter.sv
`timescale 1ns/1ps
module fsr_beat_filter #(
  parameter int TXN_W = 4,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_ev,
  input  logic [TXN_W-1:0]  txn,
  input  logic [BEAT_W-1:0] beat,
  output logic              drop
);
  logic             trk_vld;
  logic [TXN_W-1:0] trk_txn;
  logic             pass;

  // A beat-0 event always opens a fresh transaction window.
  assign drop = ecc_ev & trk_vld & (txn == trk_txn) & (beat != '0);
  assign pass = ecc_ev & ~drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk_vld <= 1'b0;
      trk_txn <= '0;
    end else if (pass) begin
      trk_vld <= 1'b1;
      trk_txn <= txn;
    end
  end
endmodule

// File: rtl/fsr_cap_slot.sv
`timescale 1ns/1ps
module fsr_cap_slot import fsr_pkg::*; #(
  parameter int W = 8,
  parameter int NF = 19,
  parameter int IDX_W = 5,
  parameter logic [NF-1:0] MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [IDX_W-1:0] idx,
  input  cls_e             cls,
  input  logic [W-1:0]     val,
  input  logic [NF-1:0]    clr_vec,
  output logic [W-1:0]     q,
  output logic             lk_vld,
  output logic [IDX_W-1:0] lk_idx
);
  localparam int SZ = 1 << IDX_W;
  localparam int KW = IDX_W + 2;
  localparam logic [SZ-1:0] MPAD = SZ'(MASK);

  logic [SZ-1:0] clr_pad;
  logic [KW-1:0] ev_key, lk_key;
  logic          unlock, held, take;

  assign clr_pad = SZ'(clr_vec);
  assign ev_key  = {cls, idx};
  assign unlock  = lk_vld & clr_pad[lk_idx];
  assign held    = lk_vld & ~unlock;
  assign take    = acc & MPAD[idx] & (~held | (ev_key > lk_key));
  assign lk_idx  = lk_key[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q      <= '0;
      lk_vld <= 1'b0;
      lk_key <= '0;
    end else if (take) begin
      q      <= val;
      lk_vld <= 1'b1;
      lk_key <= ev_key;
    end else if (unlock) begin
      lk_vld <= 1'b0;
    end
  end

  AST_LOCK_KEY_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> (lk_vld && (lk_key >= $past(lk_key)))); // R6
  AST_HELD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !(acc && MPAD[idx])) |=> $stable(q)); // R7
endmodule

// File: rtl/fault_status_log.sv
`timescale 1ns/1ps
module fault_status_log import fsr_pkg::*; #(
  parameter int NF = 19,
  parameter int FLAG_LO = 33,
  parameter int ADDR_W = 40,
  parameter int TXN_W = 4,
  parameter int BEAT_W = 2,
  parameter logic [NF-1:0] HWC_MASK  = 19'h0A0A9,
  parameter logic [NF-1:0] SWC_MASK  = 19'h00200,
  parameter logic [NF-1:0] ECC_MASK  = 19'h0F003,
  parameter logic [NF-1:0] TRAP_MASK = 19'h7FFFF,
  parameter logic [NF-1:0] ADDR_MASK = 19'h7FFFF,
  parameter logic [NF-1:0] ESYN_MASK = 19'h037FF,
  parameter logic [NF-1:0] MSYN_MASK = 19'h0C000,
  localparam int IDX_W = $clog2(NF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [REG_W-1:0]  csr_wdata,
  output logic [REG_W-1:0]  csr_rdata,
  input  logic              ev_vld,
  input  logic [IDX_W-1:0]  ev_idx,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [ESYN_W-1:0] ev_esyn,
  input  logic [MSYN_W-1:0] ev_msyn,
  input  logic [TXN_W-1:0]  ev_txn,
  input  logic [BEAT_W-1:0] ev_beat,
  input  logic              ev_priv,
  input  logic              irq_en,
  output logic              trap_req,
  output logic [ADDR_W-1:0] cap_addr
);
  localparam int SZ = 1 << IDX_W;
  localparam logic [SZ-1:0] TRAP_PAD = SZ'(TRAP_MASK);

  logic              in_rng, is_ecc, drop, acc, dup, me_set;
  logic              wr_me_clr, wr_priv_clr, unused_wr;
  cls_e              ev_cls;
  logic [NF-1:0]     fl_q, fl_n, clr_vec, set_vec;
  logic [SZ-1:0]     fl_pad;
  logic              me_q, priv_q;
  logic [ESYN_W-1:0] esyn_q;
  logic [MSYN_W-1:0] msyn_q;
  logic              a_lk, e_lk, m_lk;
  logic [IDX_W-1:0]  a_li, e_li, m_li;

  fsr_classify #(.NF(NF), .IDX_W(IDX_W), .HWC_MASK(HWC_MASK),
                 .SWC_MASK(SWC_MASK), .ECC_MASK(ECC_MASK)) u_cls (
    .idx(ev_idx), .in_rng(in_rng), .cls(ev_cls), .is_ecc(is_ecc));

  fsr_beat_filter #(.TXN_W(TXN_W), .BEAT_W(BEAT_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .ecc_ev(ev_vld & is_ecc),
    .txn(ev_txn), .beat(ev_beat), .drop(drop));

  // Event / write decode
  assign acc         = ev_vld & in_rng & ~drop;
  assign set_vec     = acc ? (NF'(1) << ev_idx) : '0;
  assign clr_vec     = csr_we ? csr_wdata[FLAG_LO +: NF] : '0;
  assign wr_me_clr   = csr_we & csr_wdata[POS_ME];
  assign wr_priv_clr = csr_we & csr_wdata[POS_PRIV];
  assign dup         = |(fl_q & ~clr_vec & set_vec);
  assign me_set      = acc & dup & repeat_counts(ev_cls);
  assign fl_n        = (fl_q & ~clr_vec) | set_vec;
  assign fl_pad      = SZ'(fl_q);
  assign unused_wr   = ^csr_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fl_q   <= '0;
      me_q   <= 1'b0;
      priv_q <= 1'b0;
    end else begin
      fl_q   <= fl_n;
      me_q   <= (me_q & ~wr_me_clr) | me_set;
      priv_q <= acc ? ev_priv : (priv_q & ~wr_priv_clr);
    end
  end

  // Independent capture slots
  fsr_cap_slot #(.W(ADDR_W), .NF(NF), .IDX_W(IDX_W), .MASK(ADDR_MASK)) u_cap_a (
    .clk(clk), .rst_n(rst_n), .acc(acc), .idx(ev_idx), .cls(ev_cls),
    .val(ev_addr), .clr_vec(clr_vec), .q(cap_addr), .lk_vld(a_lk), .lk_idx(a_li));

  fsr_cap_slot #(.W(ESYN_W), .NF(NF), .IDX_W(IDX_W), .MASK(ESYN_MASK)) u_cap_e (
    .clk(clk), .rst_n(rst_n), .acc(acc), .idx(ev_idx), .cls(ev_cls),
    .val(ev_esyn), .clr_vec(clr_vec), .q(esyn_q), .lk_vld(e_lk), .lk_idx(e_li));

  fsr_cap_slot #(.W(MSYN_W), .NF(NF), .IDX_W(IDX_W), .MASK(MSYN_MASK)) u_cap_m (
    .clk(clk), .rst_n(rst_n), .acc(acc), .idx(ev_idx), .cls(ev_cls),
    .val(ev_msyn), .clr_vec(clr_vec), .q(msyn_q), .lk_vld(m_lk), .lk_idx(m_li));

  always_comb begin
    csr_rdata = '0;
    csr_rdata[FLAG_LO +: NF]      = fl_q;
    csr_rdata[POS_ME]             = me_q;
    csr_rdata[POS_PRIV]           = priv_q;
    csr_rdata[POS_MSYN +: MSYN_W] = msyn_q;
    csr_rdata[POS_ESYN +: ESYN_W] = esyn_q;
  end

  assign trap_req = irq_en & |(fl_q & TRAP_MASK);

  AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ((~fl_q & $past(fl_q) & ~$past(clr_vec)) == '0)); // R1
  AST_ME_HWC_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ev_cls == CLS_HWC && !me_q && !csr_we) |=> !me_q); // R3
  AST_BEAT_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !csr_we) |=> ($stable(fl_q) && $stable(me_q) && $stable(cap_addr))); // R4
  AST_LOCK_OWNER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    a_lk |-> fl_pad[a_li]); // R7
  AST_LOCK_OWNER_ESYN: assert property (@(posedge clk) disable iff (!rst_n)
    e_lk |-> fl_pad[e_li]); // R8
  AST_LOCK_OWNER_MSYN: assert property (@(posedge clk) disable iff (!rst_n)
    m_lk |-> fl_pad[m_li]); // R8
  AST_TRAP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && TRAP_PAD[ev_idx]) |=> (trap_req || !irq_en)); // R9
  AST_SAME_CYCLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> fl_pad[$past(ev_idx)]); // R10
  AST_RANGE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vld && !in_rng && !csr_we) |=> ($stable(fl_q) && $stable(priv_q))); // R12
endmodule

// File: tb/fault_status_log_tb.sv
`timescale 1ns/1ps
module fault_status_log_tb;
  localparam int NF = 6;
  localparam int LO = 33;
  localparam int AW = 16;
  localparam int TW = 3;
  localparam int BW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          csr_we = 1'b0;
  logic [63:0]   csr_wdata = '0;
  logic [63:0]   csr_rdata;
  logic          ev_vld = 1'b0;
  logic [2:0]    ev_idx = '0;
  logic [AW-1:0] ev_addr = '0;
  logic [8:0]    ev_esyn = '0;
  logic [3:0]    ev_msyn = '0;
  logic [TW-1:0] ev_txn = '0;
  logic [BW-1:0] ev_beat = '0;
  logic          ev_priv = 1'b0;
  logic          irq_en = 1'b1;
  logic          trap_req;
  logic [AW-1:0] cap_addr;

  fault_status_log #(
    .NF(NF), .FLAG_LO(LO), .ADDR_W(AW), .TXN_W(TW), .BEAT_W(BW),
    .HWC_MASK(6'b001001), .SWC_MASK(6'b000010), .ECC_MASK(6'b001111),
    .TRAP_MASK(6'b001011), .ADDR_MASK(6'b111111),
    .ESYN_MASK(6'b001111), .MSYN_MASK(6'b011000)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .ev_vld(ev_vld), .ev_idx(ev_idx), .ev_addr(ev_addr),
    .ev_esyn(ev_esyn), .ev_msyn(ev_msyn), .ev_txn(ev_txn), .ev_beat(ev_beat),
    .ev_priv(ev_priv), .irq_en(irq_en), .trap_req(trap_req), .cap_addr(cap_addr));

  int total = 0;
  int bad = 0;
  bit done = 0;
  int seq = 1;

  // Bench-side model state
  bit [NF-1:0] m_fl;
  bit          m_me, m_priv;
  bit [AW-1:0] m_addr;
  bit [8:0]    m_esyn;
  bit [3:0]    m_msyn;
  bit          lk_v [3];
  int          lk_r [3];
  bit          t_vld;
  int          t_txn;

  // class: 0 hw-corrected, 1 sw-correctable, 2 uncorrectable
  function automatic int cls_of(int i);
    if (i == 0 || i == 3) return 0;
    if (i == 1) return 1;
    return 2;
  endfunction
  function automatic int rank_of(int i);
    return cls_of(i) * 8 + i;
  endfunction
  function automatic bit in_slot(int s, int i);
    if (s == 0) return 1'b1;
    if (s == 1) return (i <= 3);
    return (i == 3 || i == 4);
  endfunction
  function automatic bit trap_of(int i);
    return (i == 0 || i == 1 || i == 3);
  endfunction
  function automatic logic [63:0] flag_bit(int i);
    return 64'(1) << (LO + i);
  endfunction

  task automatic mdl_reset();
    m_fl = '0; m_me = 0; m_priv = 0; m_addr = '0; m_esyn = '0; m_msyn = '0;
    for (int s = 0; s < 3; s++) begin lk_v[s] = 0; lk_r[s] = 0; end
    t_vld = 0; t_txn = 0;
  endtask

  task automatic step(input bit we, input logic [63:0] wd, input bit vld,
                      input int idx, input int txn, input int beat, input bit priv);
    bit [NF-1:0] clr;
    bit in_rng, ecc, drp, acc, me_set;
    logic [AW-1:0] a;
    logic [8:0] e;
    logic [3:0] m;
    a = AW'(16'hA000 ^ (seq * 37));
    e = 9'(seq * 11);
    m = 4'(seq);
    seq++;
    csr_we = we; csr_wdata = wd; ev_vld = vld; ev_idx = 3'(idx);
    ev_addr = a; ev_esyn = e; ev_msyn = m; ev_txn = TW'(txn);
    ev_beat = BW'(beat); ev_priv = priv;
    clr    = we ? wd[LO +: NF] : '0;
    in_rng = (idx < NF);
    ecc    = in_rng && (idx <= 3);
    drp    = vld && ecc && t_vld && (txn == t_txn) && (beat != 0);
    acc    = vld && in_rng && !drp;
    if (vld && ecc && !drp) begin t_vld = 1; t_txn = txn; end
    for (int s = 0; s < 3; s++)
      if (lk_v[s] && clr[lk_r[s] % 8]) lk_v[s] = 0;
    me_set = acc && m_fl[idx] && !clr[idx] && (cls_of(idx) != 0);
    m_fl   = m_fl & ~clr;
    if (acc) m_fl[idx] = 1'b1;
    m_me   = (m_me & !(we && wd[53])) | me_set;
    m_priv = acc ? priv : (m_priv & !(we && wd[52]));
    if (acc)
      for (int s = 0; s < 3; s++)
        if (in_slot(s, idx) && (!lk_v[s] || rank_of(idx) > lk_r[s])) begin
          lk_v[s] = 1; lk_r[s] = rank_of(idx);
          if (s == 0) m_addr = a;
          if (s == 1) m_esyn = e;
          if (s == 2) m_msyn = m;
        end
    @(posedge clk);
    @(negedge clk);
    csr_we = 0; ev_vld = 0;
  endtask

  task automatic ev(input int idx, input int txn, input int beat, input bit priv);
    step(0, '0, 1, idx, txn, beat, priv);
  endtask
  task automatic wr(input logic [63:0] wd);
    step(1, wd, 0, 0, 0, 0, 0);
  endtask

  task automatic check(input string tag);
    logic [63:0] exp;
    bit et;
    exp = '0;
    exp[LO +: NF] = m_fl;
    exp[53] = m_me;
    exp[52] = m_priv;
    exp[19:16] = m_msyn;
    exp[8:0] = m_esyn;
    et = 0;
    for (int i = 0; i < NF; i++) if (m_fl[i] && trap_of(i)) et = irq_en;
    total++;
    if (csr_rdata !== exp || cap_addr !== m_addr || trap_req !== et) begin
      bad++;
      $display("FAIL %s rdata=%h exp=%h addr=%h exp=%h trap=%b exp=%b",
               tag, csr_rdata, exp, cap_addr, m_addr, trap_req, et);
    end
  endtask

  initial begin
    #(500000.0);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R11 watchdog expired act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mdl_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R11 reset state");

    // R2: zero write, syndrome writes, idle reads
    ev(1, 1, 0, 0);
    check("R1 set");
    wr(64'h0);
    check("R2 zero write");
    wr(64'h000F_01FF);
    check("R2 syndrome write ignored");
    repeat (4) @(negedge clk);
    check("R2 read no side effect");

    // R12: out-of-range indices
    ev(6, 4, 0, 1);
    ev(7, 5, 0, 1);
    check("R12 out-of-range ignored");

    // R5: privilege sample
    ev(2, 0, 0, 1);
    check("R5 priv sampled 1");
    ev(4, 0, 0, 0);
    check("R5 priv sampled 0");
    ev(5, 0, 0, 1);
    wr(64'(1) << 52);
    check("R5 priv cleared");

    // R3: repeats per class
    wr('1);
    ev(0, 0, 0, 0); ev(3, 1, 0, 0); ev(0, 2, 0, 0);
    check("R3 hw-corrected repeat no ME");
    ev(1, 3, 0, 0); ev(1, 4, 0, 0);
    check("R3 sw-correctable repeat sets ME");
    wr(64'(1) << 53);
    check("R3 ME cleared");

    // R4: sub-beat filter
    wr('1);
    ev(0, 2, 1, 0);
    check("R4 first ecc logged");
    ev(1, 2, 2, 1);
    check("R4 later sub-beat dropped");
    ev(0, 2, 3, 1);
    check("R4 repeat in txn dropped");
    ev(2, 2, 0, 1);
    check("R4 beat 0 opens new txn");
    ev(3, 2, 1, 0);
    check("R4 drop after reopen");
    ev(4, 2, 3, 1);
    check("R4 non-ecc not filtered");
    ev(3, 6, 2, 0);
    check("R4 other txn accepted");

    // R10: same-cycle clear and event
    wr('1);
    ev(2, 0, 0, 0);
    step(1, flag_bit(2), 1, 2, 0, 0, 1);
    check("R10 event wins over clear");
    ev(4, 0, 0, 0);
    step(1, flag_bit(4), 1, 0, 1, 0, 0);
    check("R10 R7 released lock retaken");

    // R9: trap gating per flag
    for (int i = 0; i < NF; i++)
      for (int en = 0; en < 2; en++) begin
        wr('1);
        irq_en = en[0];
        ev(i, i, 0, 0);
        check("R9 trap request");
      end
    irq_en = 1'b1;

    // R6 R7 R8: ordered pair sweep with third event after release
    for (int a = 0; a < NF; a++)
      for (int b = 0; b < NF; b++) begin
        wr('1);
        ev(a, 0, 0, a[0]);
        ev(b, 1, 0, b[0]);
        check("R6 R8 R3 pair capture");
        wr(flag_bit(a));
        check("R7 owner clear");
        ev((a + b + 1) % NF, 2, 0, 1);
        check("R7 R8 capture after release");
        wr(flag_bit(b));
        ev(a, 3, 0, 0);
        check("R1 R6 re-log after clear");
      end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule